// File: doc/BRIEF.md
# Prescaled Baud Tick Generator

This block turns the system clock into the oversampling strobe a UART needs: a one-cycle pulse at sixteen times the serial bit rate. The clock passes first through a programmable prescaler that divides by 65 minus a 6-bit field. The prescaler's output then steps a second counter that divides by a power of two chosen by a 3-bit code. The strobe period is therefore N = (65 - field) * 2^code system clocks. The bit rate is the clock divided by the prescaler ratio, then by the power of two, then by 16.

A module enable gates the whole block. While the enable is low, both counters are held at zero and no strobe is produced, so the block draws no switching power. The enable comes out of reset low. When the enable rises, counting starts from zero. If the prescaler field or the divide code changes while the block runs, both counters restart from zero, so the new rate takes effect from a full period and never from a partial one. Prescaler values above 64 are clamped to 64, which gives division by one. With the default 6-bit field no such value can be presented.

All pins are plain control and status signals. The block has no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is low and after it is released with the enable low, `tick` is 0.
- R2: The prescaler divides the clock by 65 minus `presc_field`, read as an unsigned number. A field of 0 gives division by 65 and a field of 63 gives division by 2.
- R3: `div_code` divides the prescaler output by 2 to the power of the code, read as an unsigned number: code 0 gives 1, code 1 gives 2, and so on up to code 7, which gives 128.
- R4: With the enable high and the configuration unchanged, `tick` is high on every N-th cycle, where N = (65 - presc_field) * 2^div_code, and low on all other cycles. The first pulse follows the N-th rising clock edge at which the enable is sampled high.
- R5: Each pulse on `tick` lasts exactly one clock cycle.
- R6: While the enable is low, `tick` stays 0 and both counters are held at zero. After the enable returns high, the first pulse follows the N-th rising edge, as in R4.
- R7: A change of `presc_field` or `div_code` while the enable is high restarts both counters. `tick` is 0 in the cycle after the edge that samples the change. The next pulse follows the N-th edge after that edge, where N is computed from the new values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable. When low, the counters are held idle. |
| presc_field | input | 6 | Prescaler setting. The prescaler ratio is 65 minus this value. |
| div_code | input | 3 | Power-of-two divide select |
| tick | output | 1 | One-cycle strobe at 16 times the bit rate |

## Verification
The output is registered once after the counters. A pulse therefore appears in the cycle that follows the N-th rising edge after the enable is sampled high. After a configuration change it appears after edge N+1, counting the edge that samples the change as edge 1. The bench drives every input just after a falling edge. It then counts each rising edge and samples `tick` at the falling edge that follows, comparing it with an expected pattern of one pulse every N edges. The pattern is built from the field and code alone. A pulse that arrives one cycle early or late is reported at the exact edge where it occurs.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

  // Prescaler ratio: base minus the field, with the field clamped so the
  // ratio never falls below one.
  function automatic int unsigned presc_ratio(input int unsigned field,
                                              input int unsigned base);
    int unsigned f;
    f = (field > base - 1) ? base - 1 : field;
    return base - f;
  endfunction

endpackage

// File: rtl/bt_cfg_watch.sv
module bt_cfg_watch #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] cfg,
  output logic         restart
);

  logic [W-1:0] cfg_q;

  // The copy follows the inputs even while idle, so a setting written
  // while disabled is not taken as a change later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg;
  end

  assign restart = run && (cfg != cfg_q);

endmodule

// File: rtl/bt_prescaler.sv
module bt_prescaler #(
  parameter int PRESC_W    = 6,
  parameter int PRESC_BASE = 65
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               clear,
  input  logic [PRESC_W-1:0] field,
  output logic               stb
);

  localparam int CNT_W = $clog2(PRESC_BASE + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;
  logic             at_term;

  always_comb begin
    term = CNT_W'(baud_tick_pkg::presc_ratio(32'(field), PRESC_BASE) - 1);
  end

  assign at_term = (cnt_q == term);
  assign stb     = run && !clear && at_term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run || clear)  cnt_q <= '0;
    else if (at_term)        cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/bt_pow2_div.sv
module bt_pow2_div #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clear,
  input  logic              step,
  input  logic [CODE_W-1:0] code,
  output logic              wrap
);

  localparam int EXP_MAX = (1 << CODE_W) - 1;
  localparam int CNT_W   = (EXP_MAX > 0) ? EXP_MAX : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;

  // Terminal count 2^code - 1: one mask bit per possible exponent.
  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign mask[i] = (32'(code) > i);
  end

  assign wrap = step && (cnt_q == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || clear) cnt_q <= '0;
    else if (step)          cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int PRESC_W    = 6,
  parameter int CODE_W     = 3,
  parameter int PRESC_BASE = 65
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [PRESC_W-1:0] presc_field,
  input  logic [CODE_W-1:0]  div_code,
  output logic               tick
);

  logic restart;
  logic pre_stb;
  logic div_wrap;
  logic tick_q;

  bt_cfg_watch #(.W(PRESC_W + CODE_W)) u_watch (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (enable),
    .cfg     ({presc_field, div_code}),
    .restart (restart)
  );

  bt_prescaler #(.PRESC_W(PRESC_W), .PRESC_BASE(PRESC_BASE)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (enable),
    .clear (restart),
    .field (presc_field),
    .stb   (pre_stb)
  );

  bt_pow2_div #(.CODE_W(CODE_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (enable),
    .clear (restart),
    .step  (pre_stb),
    .code  (div_code),
    .wrap  (div_wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 tick_q <= 1'b0;
    else if (!enable || restart) tick_q <= 1'b0;
    else                        tick_q <= div_wrap;
  end

  assign tick = tick_q;

endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int PRESC_W    = 6,
  parameter int CODE_W     = 3,
  parameter int PRESC_BASE = 65
) (
  input logic               clk,
  input logic               rst_n,
  input logic               enable,
  input logic [PRESC_W-1:0] presc_field,
  input logic [CODE_W-1:0]  div_code,
  input logic               tick
);

  logic [PRESC_W+CODE_W-1:0] seen_q;
  logic                      changed;
  int unsigned               gap_q;
  int unsigned               exp_n;
  int unsigned               fld;

  always_comb begin
    fld = 32'(presc_field);
    if (fld > PRESC_BASE - 1) fld = PRESC_BASE - 1;
    exp_n = (PRESC_BASE - fld) << div_code;
  end

  assign changed = ({presc_field, div_code} != seen_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      gap_q  <= 0;
    end else begin
      seen_q <= {presc_field, div_code};
      if (!enable || changed) gap_q <= 0;
      else if (tick)          gap_q <= 1;
      else                    gap_q <= gap_q + 1;
    end
  end

  // R5: one-cycle pulse
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R6: quiet while disabled
  assert_quiet_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !tick);

  // R7: a change suppresses the next cycle's tick
  assert_restart_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && changed) |=> !tick);

  // R4: spacing between pulses equals the programmed period
  assert_period_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !changed) |-> (gap_q == exp_n));

  // R4: no pulse is skipped
  assert_no_late_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !changed) |-> (gap_q <= exp_n));

endmodule

bind baud_tick_gen baud_tick_gen_chk #(
  .PRESC_W(PRESC_W), .CODE_W(CODE_W), .PRESC_BASE(PRESC_BASE)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .presc_field (presc_field),
  .div_code    (div_code),
  .tick        (tick)
);

// File: tb/baud_tick_gen_tb_top.sv
module baud_tick_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [5:0] presc_field = '0;
  logic [2:0] div_code = '0;
  logic       tick;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  baud_tick_gen dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .presc_field (presc_field),
    .div_code    (div_code),
    .tick        (tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int period(input int f, input int c);
    return (65 - f) << c;
  endfunction

  // Runs `edges` rising edges, sampling at each following falling edge.
  // A pulse is expected whenever (edge - offset) is a positive multiple of n.
  task automatic scan(input int edges, input int n, input int offset,
                      input string req, output int bad, output int first_bad,
                      output int got, output int pulses);
    bad = 0; first_bad = -1; got = 0; pulses = 0;
    for (int e = 1; e <= edges; e++) begin
      bit exp;
      @(posedge clk); @(negedge clk);
      exp = (e > offset) && (((e - offset) % n) == 0);
      if (tick) pulses++;
      if (tick !== exp) begin
        if (bad == 0) begin first_bad = e; got = int'(tick); end
        bad++;
      end
    end
    if (bad != 0)
      $display("  %s: first miscompare at edge %0d", req, first_bad);
  endtask

  task automatic setup(input int f, input int c);
    @(negedge clk);
    enable = 1'b0;
    presc_field = 6'(f);
    div_code = 3'(c);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(tick === 1'b0, "R1 tick low in reset", int'(tick), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(tick === 1'b0, "R1 tick low after reset, enable low", int'(tick), 0);
  endtask

  task automatic t_rate(input int f, input int c, input int count, input string req);
    int n, bad, fb, got, pulses;
    n = period(f, c);
    setup(f, c);
    enable = 1'b1;
    scan(n * count, n, 0, req, bad, fb, got, pulses);
    check(bad == 0, req, got, (fb < 0) ? 0 : int'(fb % n == 0));
    check(pulses == count, {req, " R5 pulse count"}, pulses, count);
  endtask

  task automatic t_restart;
    int n, bad, fb, got, pulses;
    setup(60, 0);
    enable = 1'b1;
    repeat (7) @(negedge clk);
    presc_field = 6'd61;
    div_code = 3'd1;
    n = period(61, 1);
    scan(3 * n + 1, n, 1, "R7 restart on change", bad, fb, got, pulses);
    check(bad == 0, "R7 restart on change", got, 1 - got);
    check(pulses == 3, "R7 pulses after change", pulses, 3);
  endtask

  task automatic t_disable;
    int n, bad, fb, got, pulses;
    n = period(59, 1);
    setup(59, 1);
    enable = 1'b1;
    repeat (7) @(negedge clk);
    enable = 1'b0;
    scan(40, 40000, 0, "R6 idle", bad, fb, got, pulses);
    check(pulses == 0, "R6 no tick while disabled", pulses, 0);
    enable = 1'b1;
    scan(2 * n, n, 0, "R6 re-enable", bad, fb, got, pulses);
    check(bad == 0 && pulses == 2, "R6 full period after re-enable", pulses, 2);
  endtask

  initial begin
    #(120000 * 10);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_rate(63, 0, 4, "R2 field 63 ratio 2");
    t_rate(0, 0, 3, "R2 field 0 ratio 65");
    t_rate(60, 3, 4, "R3 code 3");
    t_rate(50, 2, 3, "R4 period 60");
    t_rate(62, 7, 3, "R3 code 7");
    t_rate(0, 7, 1, "R4 longest period");
    t_restart();
    t_disable();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule